// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block runs the bus cycles an 8-bit processor core performs between the release of its active-low reset pin and the first instruction fetch. It does not jump straight to the vector. Instead, it replays the seven-cycle microsequence of the break instruction. While that sequence runs, the predecode path presents opcode 00 to the core, whatever byte sits on the data bus.

The seven cycles are:

- an opcode fetch;
- a read whose data is thrown away;
- three cycles addressed to the stack page;
- a read of the low vector byte from the vector address;
- a read of the high vector byte from the next address.

During reset the three stack cycles stay reads, so memory is left untouched. Once the vector is assembled into the program counter, a one-cycle done flag marks the cycle in which execution begins at the new address.

Top module: `reset_vector_seq`

## Requirements
- R1: While `rst_n` is low, `done` and `op_override` are 0, `sp` equals SP_INIT (default 0x00), `pc` equals PC_INIT (default 0x0000) and `addr` equals `pc`. The reset takes effect at once, without waiting for a clock edge.
- R2: The clock edge that first sees `rst_n` high starts cycle 0. In cycle 0, `addr` equals `pc`, `op_override` is 1 and `opcode` is 0x00 for any `din`.
- R3: `op_override` is 1 in cycles 0 through 6 and 0 at all other times. When it is 1, `opcode` is 0x00; when it is 0, `opcode` equals `din`.
- R4: Cycle 1 is a dummy read at `addr` = `pc`. The `din` value in cycle 1 has no effect on `pc` or `sp`.
- R5: Cycles 2, 3 and 4 drive `addr` = 0x0100 | `sp`. `sp` drops by one at the end of each of these cycles, so it ends at SP_INIT minus 3 (0xFD by default).
- R6: `rw` is 1 (read) in every cycle, including the three stack cycles.
- R7: Cycle 5 drives `addr` = 0xFFFC and latches `din` as the low vector byte. Cycle 6 drives `addr` = 0xFFFD and takes `din` as the high vector byte.
- R8: In the cycle after cycle 6, `done` is 1 for exactly one cycle, and `pc` and `addr` both equal {high byte, low byte}. After that, `done` stays 0 and `pc` holds its value until the next reset.
- R9: If `rst_n` goes low partway through the sequence, the block returns to the R1 state. On the next release it restarts from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset pin; its release starts the sequence |
| din | input | 8 | Data bus in |
| addr | output | 16 | Address bus |
| rw | output | 1 | Read/write strobe, 1 = read |
| opcode | output | 8 | Byte handed to predecode (forced to 0x00 during the sequence) |
| op_override | output | 1 | High while predecode is forced |
| sp | output | 8 | Stack pointer |
| pc | output | 16 | Program counter |
| done | output | 1 | One-cycle pulse when execution starts at the vector |

## Verification
The bench sweeps vectors that include 0x0000, 0xFFFF, 0x00FF and 0xFF00. A design that swapped the two vector bytes, or latched them one cycle off, would load the wrong program counter. Data-bus garbage is driven in the fetch and dummy-read cycles, which would expose a design that let `din` through predecode or into the program counter too early. The bench also re-asserts reset in each of the seven cycles. A block that resumed rather than restarted would show a wrong address or a stack pointer that had already been decremented. Stack addresses are checked in every stack cycle, and `rw` in every cycle, which catches a design that wrote to the stack page during reset.

// File: rtl/rvf_pkg.sv
package rvf_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_C0,
      ST_C1,
      ST_C2,
      ST_C3,
      ST_C4,
      ST_C5,
      ST_C6,
      ST_DONE,
      ST_RUN
   } rvf_state_t;

   localparam int unsigned SEQ_LEN = 7;
endpackage

// File: rtl/rvf_seq_ctrl.sv
module rvf_seq_ctrl
   import rvf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   output logic seq_active,
   output logic stack_cyc,
   output logic vlo_cyc,
   output logic vhi_cyc,
   output logic done_cyc
);
   rvf_state_t st_q, st_d;

   always_comb begin
      case (st_q)
         ST_IDLE: st_d = ST_C0;
         ST_C0:   st_d = ST_C1;
         ST_C1:   st_d = ST_C2;
         ST_C2:   st_d = ST_C3;
         ST_C3:   st_d = ST_C4;
         ST_C4:   st_d = ST_C5;
         ST_C5:   st_d = ST_C6;
         ST_C6:   st_d = ST_DONE;
         ST_DONE: st_d = ST_RUN;
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign seq_active = (st_q >= ST_C0) && (st_q <= ST_C6);
   assign stack_cyc  = (st_q == ST_C2) || (st_q == ST_C3) || (st_q == ST_C4);
   assign vlo_cyc    = (st_q == ST_C5);
   assign vhi_cyc    = (st_q == ST_C6);
   assign done_cyc   = (st_q == ST_DONE);
endmodule

// File: rtl/rvf_regs.sv
module rvf_regs #(
   parameter int unsigned   DATA_W  = 8,
   parameter int unsigned   ADDR_W  = 16,
   parameter logic [7:0]    SP_INIT = 8'h00,
   parameter logic [15:0]   PC_INIT = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              stack_cyc,
   input  logic              vlo_cyc,
   input  logic              vhi_cyc,
   output logic [DATA_W-1:0] sp_q,
   output logic [ADDR_W-1:0] pc_q
);
   logic [DATA_W-1:0] vlo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp_q <= SP_INIT[DATA_W-1:0];
      else if (stack_cyc) sp_q <= sp_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vlo_q <= '0;
      else if (vlo_cyc) vlo_q <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= PC_INIT[ADDR_W-1:0];
      else if (vhi_cyc) pc_q <= {din, vlo_q};
   end
endmodule

// File: rtl/rvf_bus_mux.sv
module rvf_bus_mux #(
   parameter int unsigned  DATA_W     = 8,
   parameter int unsigned  ADDR_W     = 16,
   parameter logic [7:0]   STACK_PAGE = 8'h01,
   parameter logic [15:0]  VEC_ADDR   = 16'hFFFC,
   parameter logic [7:0]   FORCED_OP  = 8'h00
) (
   input  logic              seq_active,
   input  logic              stack_cyc,
   input  logic              vlo_cyc,
   input  logic              vhi_cyc,
   input  logic [DATA_W-1:0] sp_q,
   input  logic [ADDR_W-1:0] pc_q,
   input  logic [DATA_W-1:0] din,
   output logic [ADDR_W-1:0] addr,
   output logic              rw,
   output logic [DATA_W-1:0] opcode
);
   localparam logic [ADDR_W-1:0] VLO_A = VEC_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] VHI_A = VLO_A + 1'b1;

   always_comb begin
      if (stack_cyc)    addr = {STACK_PAGE[DATA_W-1:0], sp_q};
      else if (vlo_cyc) addr = VLO_A;
      else if (vhi_cyc) addr = VHI_A;
      else              addr = pc_q;
   end

   // Reset flavour of the break sequence: stack cycles are reads.
   assign rw = 1'b1;

   for (genvar b = 0; b < DATA_W; b++) begin : g_pred
      assign opcode[b] = seq_active ? FORCED_OP[b] : din[b];
   end
endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq #(
   parameter int unsigned  DATA_W     = 8,
   parameter int unsigned  ADDR_W     = 16,
   parameter logic [7:0]   SP_INIT    = 8'h00,
   parameter logic [15:0]  PC_INIT    = 16'h0000,
   parameter logic [7:0]   STACK_PAGE = 8'h01,
   parameter logic [15:0]  VEC_ADDR   = 16'hFFFC,
   parameter logic [7:0]   FORCED_OP  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   output logic [ADDR_W-1:0] addr,
   output logic              rw,
   output logic [DATA_W-1:0] opcode,
   output logic              op_override,
   output logic [DATA_W-1:0] sp,
   output logic [ADDR_W-1:0] pc,
   output logic              done
);
   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("reset_vector_seq: ADDR_W must be twice DATA_W");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("reset_vector_seq: DATA_W must be 8");
   end

   logic seq_active, stack_cyc, vlo_cyc, vhi_cyc, done_cyc;

   rvf_seq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_active (seq_active),
      .stack_cyc  (stack_cyc),
      .vlo_cyc    (vlo_cyc),
      .vhi_cyc    (vhi_cyc),
      .done_cyc   (done_cyc)
   );

   rvf_regs #(
      .DATA_W (DATA_W), .ADDR_W (ADDR_W), .SP_INIT (SP_INIT), .PC_INIT (PC_INIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .stack_cyc (stack_cyc),
      .vlo_cyc   (vlo_cyc),
      .vhi_cyc   (vhi_cyc),
      .sp_q      (sp),
      .pc_q      (pc)
   );

   rvf_bus_mux #(
      .DATA_W (DATA_W), .ADDR_W (ADDR_W), .STACK_PAGE (STACK_PAGE),
      .VEC_ADDR (VEC_ADDR), .FORCED_OP (FORCED_OP)
   ) u_mux (
      .seq_active (seq_active),
      .stack_cyc  (stack_cyc),
      .vlo_cyc    (vlo_cyc),
      .vhi_cyc    (vhi_cyc),
      .sp_q       (sp),
      .pc_q       (pc),
      .din        (din),
      .addr       (addr),
      .rw         (rw),
      .opcode     (opcode)
   );

   assign op_override = seq_active;
   assign done        = done_cyc;
endmodule

// File: rtl/reset_vector_seq_chk.sv
module reset_vector_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [7:0]  din,
   input logic [15:0] addr,
   input logic [7:0]  opcode,
   input logic        op_override,
   input logic [7:0]  sp,
   input logic [15:0] pc,
   input logic        done
);
   assert_idle_R1: assert property (@(posedge clk)
      !rst_n |-> (!done && !op_override && addr == pc));

   assert_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
      op_override |-> opcode == 8'h00);

   assert_stack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sp != $past(sp)) |-> (sp == $past(sp) - 8'h01 && $past(addr) == {8'h01, $past(sp)}));

   assert_vec_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_override && addr == 16'hFFFC) |=> (op_override && addr == 16'hFFFD));

   assert_vec_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_override && addr == 16'hFFFD) |=> (done && pc[15:8] == $past(din) && addr == pc));

   assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !op_override && $stable(pc)));
endmodule

bind reset_vector_seq reset_vector_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .din         (din),
   .addr        (addr),
   .opcode      (opcode),
   .op_override (op_override),
   .sp          (sp),
   .pc          (pc),
   .done        (done)
);

// File: tb/reset_vector_seq_bench.sv
`timescale 1ns/1ps
module reset_vector_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [7:0]  din = 8'h00;
   logic [15:0] addr, pc;
   logic [7:0]  opcode, sp;
   logic        rw, op_override, done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   reset_vector_seq u_reset_vector_seq (
      .clk (clk), .rst_n (rst_n), .din (din), .addr (addr), .rw (rw),
      .opcode (opcode), .op_override (op_override), .sp (sp), .pc (pc), .done (done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [15:0] vec_of(input int k);
      case (k)
         0: return 16'h0000;
         1: return 16'hFFFF;
         2: return 16'h00FF;
         3: return 16'hFF00;
         default: return 16'((k * 16'h3A7) ^ 16'h5C21);
      endcase
   endfunction

   task automatic check_idle();
      chk("R1 done", done, 0);
      chk("R1 override", op_override, 0);
      chk("R1 sp", sp, 8'h00);
      chk("R1 pc", pc, 16'h0000);
      chk("R1 addr", addr, pc);
   endtask

   // Runs a sequence; abort_at in 0..6 re-asserts reset in that cycle, 7 runs to the end.
   task automatic run_seq(input logic [15:0] vec, input int abort_at);
      logic [7:0] exp_sp;
      rst_n = 1'b1;
      exp_sp = 8'h00;
      for (int c = 0; c < 7; c++) begin
         tick();
         din = 8'h5A ^ 8'(c * 29) ^ vec[7:0];
         #0.5;
         chk("R3 override", op_override, 1);
         chk("R3 forced", opcode, 8'h00);
         chk("R6 rw", rw, 1);
         case (c)
            0: chk("R2 fetch addr", addr, 16'h0000);
            1: chk("R4 dummy addr", addr, 16'h0000);
            2, 3, 4: begin
               chk("R5 stack addr", addr, {8'h01, exp_sp});
               exp_sp = exp_sp - 8'h01;
            end
            5: begin
               chk("R7 lo addr", addr, 16'hFFFC);
               din = vec[7:0];
            end
            default: begin
               chk("R7 hi addr", addr, 16'hFFFD);
               din = vec[15:8];
            end
         endcase
         if (c == 2) chk("R4 pc unchanged", pc, 16'h0000);
         if (c == abort_at) begin
            rst_n = 1'b0;
            #0.5;
            check_idle();
            tick();
            tick();
            check_idle();
            return;
         end
      end
      tick();
      din = 8'hA5 ^ vec[15:8];
      #0.5;
      chk("R8 done", done, 1);
      chk("R8 pc", pc, vec);
      chk("R8 addr", addr, vec);
      chk("R5 final sp", sp, 8'hFD);
      chk("R3 released", op_override, 0);
      chk("R3 passthru", opcode, din);
      tick();
      chk("R8 done once", done, 0);
      chk("R8 pc hold", pc, vec);
      tick();
      tick();
      chk("R8 stays", done, 0);
      chk("R8 pc hold2", pc, vec);
      chk("R6 rw idle", rw, 1);
      rst_n = 1'b0;
      #0.5;
      check_idle();
      tick();
      tick();
   endtask

   initial begin
      #1 rst_n = 1'b0;
      tick();
      tick();
      check_idle();
      for (int k = 0; k < 16; k++) run_seq(vec_of(k), 7);
      for (int a = 0; a < 7; a++) begin
         run_seq(16'hDEAD, a);         // R9 abort in cycle a
         run_seq(vec_of(a + 20), 7);   // R9 restart from cycle 0
      end
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule